// File: doc/BRIEF.md
# SPI Host Controller with Word Queues

This block is a bus-mapped serial peripheral host. Software writes 32-bit words into a transmit queue, then programs the word length, the target select line and that line's clocking options. Setting the exchange bit starts the transfer. The controller shifts every queued word out most significant bit first on `mosi`, and at the same time captures `miso` into a receive queue. It keeps the chosen select line asserted from the first word to the last. Software reads results from the receive queue and uses a ready flag to know when words are waiting. One interrupt line reports an empty transmit queue and/or waiting receive data, each under its own enable.

The serial bit rate comes from a separate divider. That divider delivers `bit_tick`, a one-cycle enable. Each tick moves `sclk` by one half-period. The register bus is a simple select/write strobe interface with combinational read data. Reads take effect in the cycle `bus_sel` is high.

Top module: `spi_queue_host`

## Requirements
- R1: After reset, `sclk` is 0, `irq` is 0, every select line is high (inactive), and both the control word (offset 0x08) and the status word (offset 0x18) read 0.
- R2: Registers at offsets 0x0C and 0x10 read back what was written.
  - At 0x0C, for select n (0..3), the bits kept are: n (phase), n+4 (polarity), n+12 (select level) and n+20 (idle clock level).
  - At 0x10, bits 0 and 3 are kept.
  - Every other bit reads 0.
- R3: A write to 0x08 with bit 2 and bit 0 both 1 starts an exchange. Bit 2 then reads 1 until the transmit queue is empty and the last word has shifted, and then reads 0 by itself.
- R4: Bits 24:20 of 0x08 hold the word length minus one (1 to 32 bits). Words leave MSB first. Each received word sits in the low bits of its 32-bit entry, with zeros above.
- R5: For the active select n, phase bit n = 0 samples `miso` on the leading clock edge and changes `mosi` on the trailing edge. A value of 1 samples on the trailing edge. `sclk` changes only on `bit_tick` while a word shifts.
- R6: During an exchange, `sclk` rests at polarity bit n+4 and each edge leaves that level first. Outside an exchange, `sclk` sits at idle bit n+20.
- R7: Bits 19:18 of 0x08 pick the select line. That line is driven to config bit n+12 (1 = active high, 0 = active low) for the whole exchange, including between words, with exactly one assertion per exchange. Every other line stays at the inverse of its own level bit.
- R8: Words written to 0x04 enter a transmit queue of `FIFO_DEPTH` entries. Writes are dropped while the queue is full or the block is disabled.
- R9: Reading 0x00 returns the oldest received word and removes it. It returns 0 when the receive queue is empty. Bit 3 of 0x18 reads 1 while at least one word is waiting.
- R10: A word that completes while the receive queue is full is discarded, and the words already held are kept.
- R11: `irq` is high when enable bit 0 (at 0x10) is set and the transmit queue is empty, or when enable bit 3 is set and receive data is waiting.
- R12: Writing 0 to bit 0 of 0x08 empties both queues, stops the shifter and clears the exchange bit. A later exchange then moves no words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| bit_tick | input | 1 | One-cycle enable from the divider, one per SCLK half-period |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss | output | 4 | Select lines, one per target |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with `FIFO_DEPTH` set to 4, so a handful of writes fills either queue. Within a short run it therefore covers the dropped transmit writes, the discarded receive word and a multi-word burst that empties the queue. `miso` is looped back from `mosi`. A bench-side target model samples `mosi` on the edge that the programmed phase and polarity call for, which checks both the received words and the bit order on the wire across all four select lines.

// File: rtl/spih_pkg.sv
package spih_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CS_N   = 4;
  localparam int unsigned CS_W   = $clog2(CS_N);
  localparam int unsigned LEN_W  = $clog2(DATA_W);
  localparam int unsigned EDGE_W = LEN_W + 1;

  // byte offsets decoded by software
  localparam logic [4:0] OFS_RXD = 5'h00;
  localparam logic [4:0] OFS_TXD = 5'h04;
  localparam logic [4:0] OFS_CTL = 5'h08;
  localparam logic [4:0] OFS_CFG = 5'h0C;
  localparam logic [4:0] OFS_IEN = 5'h10;
  localparam logic [4:0] OFS_STS = 5'h18;

  // field positions
  localparam int unsigned CTL_EN     = 0;
  localparam int unsigned CTL_XCH    = 2;
  localparam int unsigned CTL_MST    = 4;
  localparam int unsigned CTL_CS     = 18;
  localparam int unsigned CTL_LEN    = 20;
  localparam int unsigned CFG_PHA    = 0;
  localparam int unsigned CFG_POL    = 4;
  localparam int unsigned CFG_SSL    = 12;
  localparam int unsigned CFG_IDL    = 20;
  localparam int unsigned IEN_TXE    = 0;
  localparam int unsigned IEN_RXR    = 3;
  localparam int unsigned STS_RXR    = 3;

  typedef enum logic {SH_IDLE, SH_RUN} sh_state_e;

  typedef struct packed {
    logic [CS_N-1:0] pha;
    logic [CS_N-1:0] pol;
    logic [CS_N-1:0] ssl;
    logic [CS_N-1:0] idl;
  } lane_cfg_t;
endpackage

// File: rtl/spih_fifo.sv
module spih_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (push) wp_d = bump(wp_q);
      if (pop)  rp_d = bump(rp_q);
      cnt_d = cnt_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wp_q] <= wdata;
  end

  assign rdata = mem[rp_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/spih_shifter.sv
module spih_shifter
  import spih_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tick,
  input  logic              go,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              pha,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic              toggle,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word
);
  sh_state_e st_q, st_d;
  logic [DATA_W-1:0] sr_q, sr_d, rx_q, rx_d;
  logic [EDGE_W-1:0] k_q, k_d;
  logic tog_q, tog_d;
  logic [EDGE_W-1:0] wlen, last_k;

  assign wlen   = EDGE_W'(len_m1) + 1'b1;
  assign last_k = {len_m1, 1'b1};

  always_comb begin
    st_d  = st_q;
    sr_d  = sr_q;
    rx_d  = rx_q;
    k_d   = k_q;
    tog_d = tog_q;
    done  = 1'b0;
    if (clr) begin
      st_d  = SH_IDLE;
      k_d   = '0;
      tog_d = 1'b0;
    end else if (st_q == SH_IDLE) begin
      if (go) begin
        sr_d  = tx_word << (EDGE_W'(DATA_W) - wlen);
        rx_d  = '0;
        k_d   = '0;
        tog_d = 1'b0;
        st_d  = SH_RUN;
      end
    end else if (tick) begin
      if (k_q[0] == pha) rx_d = {rx_q[DATA_W-2:0], miso};
      else if (k_q != '0) sr_d = sr_q << 1;
      tog_d = ~tog_q;
      k_d   = k_q + 1'b1;
      if (k_q == last_k) begin
        done = 1'b1;
        st_d = SH_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SH_IDLE;
      sr_q  <= '0;
      rx_q  <= '0;
      k_q   <= '0;
      tog_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      sr_q  <= sr_d;
      rx_q  <= rx_d;
      k_q   <= k_d;
      tog_q <= tog_d;
    end
  end

  assign busy    = (st_q == SH_RUN);
  assign toggle  = tog_q;
  assign mosi    = sr_q[DATA_W-1];
  assign rx_word = rx_d;

  // R4: a word leaves the run state with the clock back at its resting level
  assert_word_even_edges_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !clr && $past(busy) && !$past(clr) && !$past(go) && (st_d == SH_IDLE) && tick) |=> !tog_q);
endmodule

// File: rtl/spi_queue_host.sv
module spi_queue_host
  import spih_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_tick,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic [3:0]  ss,
  output logic        irq
);
  logic [1:0] rsync_q;
  logic rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  logic en_q, en_d, xch_q, xch_d;
  logic [3:0] mst_q, mst_d;
  logic [CS_W-1:0] cs_q, cs_d;
  logic [LEN_W-1:0] len_q, len_d;
  lane_cfg_t cfg_q, cfg_d;
  logic [1:0] ien_q, ien_d;

  logic wr, rd, wr_ctl, wr_cfg, wr_ien;
  logic tx_push, tx_empty, tx_full, rx_pop, rx_push, rx_empty, rx_full;
  logic [DATA_W-1:0] tx_head, rx_head, rx_word;
  logic sh_busy, sh_done, sh_tog, start, fin, flush;

  assign wr      = bus_sel && bus_wr;
  assign rd      = bus_sel && !bus_wr;
  assign wr_ctl  = wr && (bus_addr == OFS_CTL);
  assign wr_cfg  = wr && (bus_addr == OFS_CFG);
  assign wr_ien  = wr && (bus_addr == OFS_IEN);
  assign tx_push = wr && (bus_addr == OFS_TXD) && en_q && !tx_full;
  assign rx_pop  = rd && (bus_addr == OFS_RXD) && !rx_empty;
  assign flush   = !en_q;
  assign start   = en_q && xch_q && !sh_busy && !tx_empty;
  assign fin     = xch_q && !sh_busy && tx_empty;
  assign rx_push = sh_done && !rx_full;

  always_comb begin
    en_d  = en_q;
    xch_d = xch_q;
    mst_d = mst_q;
    cs_d  = cs_q;
    len_d = len_q;
    cfg_d = cfg_q;
    ien_d = ien_q;
    if (wr_ctl) begin
      en_d  = bus_wdata[CTL_EN];
      mst_d = bus_wdata[CTL_MST +: 4];
      cs_d  = bus_wdata[CTL_CS +: CS_W];
      len_d = bus_wdata[CTL_LEN +: LEN_W];
    end
    if (wr_cfg) begin
      cfg_d.pha = bus_wdata[CFG_PHA +: CS_N];
      cfg_d.pol = bus_wdata[CFG_POL +: CS_N];
      cfg_d.ssl = bus_wdata[CFG_SSL +: CS_N];
      cfg_d.idl = bus_wdata[CFG_IDL +: CS_N];
    end
    if (wr_ien) ien_d = {bus_wdata[IEN_RXR], bus_wdata[IEN_TXE]};
    if (fin) xch_d = 1'b0;
    if (wr_ctl && bus_wdata[CTL_XCH]) xch_d = 1'b1;
    if (!en_d) xch_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      en_q  <= 1'b0;
      xch_q <= 1'b0;
      mst_q <= '0;
      cs_q  <= '0;
      len_q <= '0;
      cfg_q <= '0;
      ien_q <= '0;
    end else begin
      en_q  <= en_d;
      xch_q <= xch_d;
      mst_q <= mst_d;
      cs_q  <= cs_d;
      len_q <= len_d;
      cfg_q <= cfg_d;
      ien_q <= ien_d;
    end
  end

  spih_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_s_n), .flush(flush), .push(tx_push), .pop(start),
    .wdata(bus_wdata), .rdata(tx_head), .empty(tx_empty), .full(tx_full));

  spih_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_s_n), .flush(flush), .push(rx_push), .pop(rx_pop),
    .wdata(rx_word), .rdata(rx_head), .empty(rx_empty), .full(rx_full));

  spih_shifter u_shift (
    .clk(clk), .rst_n(rst_s_n), .clr(flush), .tick(bit_tick), .go(start),
    .tx_word(tx_head), .pha(cfg_q.pha[cs_q]), .len_m1(len_q), .miso(miso),
    .busy(sh_busy), .done(sh_done), .toggle(sh_tog), .mosi(mosi), .rx_word(rx_word));

  assign sclk = xch_q ? (cfg_q.pol[cs_q] ^ sh_tog) : cfg_q.idl[cs_q];

  for (genvar i = 0; i < CS_N; i++) begin : g_sel
    assign ss[i] = (xch_q && (cs_q == CS_W'(i))) ? cfg_q.ssl[i] : ~cfg_q.ssl[i];
  end

  assign irq = (ien_q[0] && tx_empty) || (ien_q[1] && !rx_empty);

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_RXD: bus_rdata = rx_empty ? '0 : rx_head;
      OFS_CTL: begin
        bus_rdata[CTL_EN]              = en_q;
        bus_rdata[CTL_XCH]             = xch_q;
        bus_rdata[CTL_MST +: 4]        = mst_q;
        bus_rdata[CTL_CS +: CS_W]      = cs_q;
        bus_rdata[CTL_LEN +: LEN_W]    = len_q;
      end
      OFS_CFG: begin
        bus_rdata[CFG_PHA +: CS_N] = cfg_q.pha;
        bus_rdata[CFG_POL +: CS_N] = cfg_q.pol;
        bus_rdata[CFG_SSL +: CS_N] = cfg_q.ssl;
        bus_rdata[CFG_IDL +: CS_N] = cfg_q.idl;
      end
      OFS_IEN: begin
        bus_rdata[IEN_TXE] = ien_q[0];
        bus_rdata[IEN_RXR] = ien_q[1];
      end
      OFS_STS: bus_rdata[STS_RXR] = !rx_empty;
      default: bus_rdata = '0;
    endcase
  end

  assert_xch_clears_when_drained_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(xch_q) |-> (!en_q || $past(tx_empty && !sh_busy)));
  assert_single_select_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    $countones(ss ^ ~cfg_q.ssl) <= 1);
  assert_sclk_only_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (sh_busy && !bit_tick && !wr_ctl && !wr_cfg) |=> $stable(sclk));
endmodule

// File: tb/spi_queue_host_bench.sv
module spi_queue_host_bench;
  localparam int DEPTH = 4;

  logic clk, rst_n, bit_tick, bus_sel, bus_wr, sclk, mosi, miso, irq;
  logic [4:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [3:0] ss;

  int total = 0, bad = 0;
  bit finished = 0;

  spi_queue_host #(.FIFO_DEPTH(DEPTH)) u_spi_queue_host (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ss(ss), .irq(irq));

  assign miso = mosi;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int tick_cnt = 0;
  always @(negedge clk) begin
    tick_cnt <= (tick_cnt == 2) ? 0 : tick_cnt + 1;
    bit_tick <= (tick_cnt == 2);
  end

  // bench-side target model
  int cur_cs = 0;
  logic cur_ssl = 1'b0, cur_pol = 1'b0, cur_pha = 1'b0;
  logic [63:0] cap = '0;
  int rises = 0, wrong = 0;
  logic prev_act = 1'b0, prev_sclk = 1'b0;
  always @(negedge clk) begin
    logic act;
    act = (ss[cur_cs] == cur_ssl);
    if (act && prev_act && (sclk != prev_sclk)) begin
      if ((prev_sclk == cur_pol) != cur_pha) cap = {cap[62:0], mosi};
    end
    if (act && !prev_act) rises++;
    for (int i = 0; i < 4; i++) if (i != cur_cs && ss[i] == 1'b0) wrong++;
    prev_act = act;
    prev_sclk = sclk;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic wait_xch();
    logic [31:0] v;
    for (int n = 0; n < 5000; n++) begin
      bread(5'h08, v);
      if (!v[2]) break;
    end
  endtask

  function automatic logic [31:0] ctl_word(input int cs, input int len, input bit xch);
    return 32'h1 | 32'hF0 | (32'(cs) << 18) | (32'(len - 1) << 20) | (xch ? 32'h4 : 32'h0);
  endfunction

  typedef struct packed {
    logic [1:0]  cs;
    logic        pha;
    logic        pol;
    logic        ssl;
    logic        idl;
    logic [5:0]  len;
    logic [31:0] tx;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd8,  32'h000000A5, 32'h000000A5},
    '{2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 6'd16, 32'h1234BEEF, 32'h0000BEEF},
    '{2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 6'd32, 32'hDEADBEEF, 32'hDEADBEEF},
    '{2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 6'd1,  32'hFFFFFFFF, 32'h00000001},
    '{2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 6'd12, 32'h0000FABC, 32'h00000ABC},
    '{2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 6'd5,  32'h0000003A, 32'h0000001A}
  };

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    #1;
    chk("R1 ss", {28'd0, ss}, 32'hF);
    chk("R1 sclk", {31'd0, sclk}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    bread(5'h18, v); chk("R1 status", v, 32'd0);
    bread(5'h08, v); chk("R1 ctrl", v, 32'd0);

    // R2: readback masks
    bwrite(5'h0C, 32'hFFFFFFFF);
    bread(5'h0C, v); chk("R2 cfg", v, 32'h00F0F0FF);
    bwrite(5'h10, 32'hFFFFFFFF);
    bread(5'h10, v); chk("R2 ien", v, 32'h00000009);
    bwrite(5'h0C, 32'h0); bwrite(5'h10, 32'h0);

    // vector table: R4 R5 R6 R7
    foreach (VECS[j]) begin
      vec_t t;
      logic [31:0] mask, exp_ss;
      t = VECS[j];
      mask = (t.len == 6'd32) ? 32'hFFFFFFFF : ((32'd1 << t.len) - 1);
      bwrite(5'h0C, (32'(t.pha) << t.cs) | (32'(t.pol) << (t.cs + 4)) |
                    (32'(t.ssl) << (t.cs + 12)) | (32'(t.idl) << (t.cs + 20)));
      bwrite(5'h08, ctl_word(int'(t.cs), int'(t.len), 1'b0));
      cur_cs = int'(t.cs); cur_ssl = t.ssl; cur_pol = t.pol; cur_pha = t.pha;
      @(negedge clk); #1;
      rises = 0; wrong = 0; cap = '0;
      chk("R6 idle level before", {31'd0, sclk}, {31'd0, t.idl});
      bwrite(5'h04, t.tx);
      bwrite(5'h08, ctl_word(int'(t.cs), int'(t.len), 1'b1));
      wait_xch();
      bread(5'h18, v); chk("R9 ready after word", v, 32'h8);
      bread(5'h00, v); chk("R4 rx word right aligned", v, t.exp);
      chk("R5 R6 wire bits at target", cap[31:0] & mask, t.exp);
      bread(5'h18, v); chk("R9 ready cleared", v, 32'h0);
      exp_ss = 32'hF;
      exp_ss[t.cs] = ~t.ssl;
      chk("R7 select released", {28'd0, ss}, exp_ss);
      chk("R7 one assertion", rises, 1);
      chk("R7 others inactive", wrong, 0);
      chk("R6 idle level after", {31'd0, sclk}, {31'd0, t.idl});
    end

    // defaults for directed tests: cs0, mode 0, low-active select
    bwrite(5'h0C, 32'h0);
    cur_cs = 0; cur_ssl = 1'b0; cur_pol = 1'b0; cur_pha = 1'b0;
    bwrite(5'h08, ctl_word(0, 8, 1'b0));

    // R11: interrupt sources
    bwrite(5'h10, 32'h1);
    #1 chk("R11 tx empty irq", {31'd0, irq}, 32'd1);
    bwrite(5'h04, 32'h5A);
    #1 chk("R11 tx not empty", {31'd0, irq}, 32'd0);
    bwrite(5'h10, 32'h8);
    bwrite(5'h08, ctl_word(0, 8, 1'b1));
    wait_xch();
    #1 chk("R11 rx ready irq", {31'd0, irq}, 32'd1);
    bread(5'h00, v); chk("R9 pop value", v, 32'h5A);
    #1 chk("R11 irq drops after pop", {31'd0, irq}, 32'd0);
    bwrite(5'h10, 32'h0);
    bread(5'h00, v); chk("R9 empty read", v, 32'h0);

    // R8 R3 R7: burst past a full queue
    @(negedge clk); #1 rises = 0; wrong = 0;
    for (int n = 1; n <= 6; n++) bwrite(5'h04, 32'(n * 32'h11));
    bwrite(5'h08, ctl_word(0, 8, 1'b1));
    bread(5'h08, v); chk("R3 busy bit set", v & 32'h4, 32'h4);
    wait_xch();
    bread(5'h08, v); chk("R3 busy bit self clears", v & 32'h4, 32'h0);
    chk("R7 held across words", rises, 1);
    for (int n = 1; n <= DEPTH; n++) begin
      bread(5'h00, v); chk("R8 queued words", v, 32'(n * 32'h11));
    end
    bread(5'h18, v); chk("R8 extra writes dropped", v, 32'h0);

    // R10: completion into a full receive queue
    for (int n = 0; n < DEPTH; n++) bwrite(5'h04, 32'h81 + 32'(n));
    bwrite(5'h08, ctl_word(0, 8, 1'b1));
    wait_xch();
    bwrite(5'h04, 32'h99);
    bwrite(5'h08, ctl_word(0, 8, 1'b1));
    wait_xch();
    for (int n = 0; n < DEPTH; n++) begin
      bread(5'h00, v); chk("R10 held words kept", v, 32'h81 + 32'(n));
    end
    bread(5'h18, v); chk("R10 late word discarded", v, 32'h0);

    // R12: disable flushes
    bwrite(5'h04, 32'h42);
    bwrite(5'h08, ctl_word(0, 8, 1'b1));
    wait_xch();
    bwrite(5'h04, 32'h17);
    bwrite(5'h04, 32'h18);
    bwrite(5'h08, 32'h0);
    bread(5'h18, v); chk("R12 rx flushed", v, 32'h0);
    bwrite(5'h04, 32'h19);
    bwrite(5'h08, ctl_word(0, 8, 1'b1));
    repeat (60) @(negedge clk);
    bread(5'h08, v); chk("R12 empty exchange ends", v & 32'h4, 32'h0);
    bread(5'h18, v); chk("R12 tx flushed", v, 32'h0);
    #1 chk("R12 select idle", {28'd0, ss}, 32'hF);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule